// File: doc/BRIEF.md
# ADC Lane Serializer

This block turns one channel of parallel 10-bit converter results into a single serial lane. Alongside the data it drives a bit clock and a frame marker, so a receiver can recover the bits and find word boundaries. Run-time controls choose several things:

- the output code: offset binary, or two's complement;
- which end of the word leaves first;
- double- or single-rate bit timing;
- in single-rate mode, which bit-clock edge sits in the middle of each bit;
- in double-rate mode, the phase of the bit clock;
- two fixed test patterns that take the place of the sample data.

The model is fully digital. One `clk` cycle is half a bit period, and the sample clock is implied by the frame length. A double-rate frame is 20 ticks and carries 10 bits. A single-rate frame is 24 ticks and carries 12 bit slots. The block captures the sample input and every control input together on the last tick of a frame. Those values stay in force for the whole of the next frame, so a frame is never built from two settings. After reset, the first frame is sent with default settings and an all-zero word. The sample offered upstream is taken at the next frame boundary.

Top module: `adc_lane_serializer`

## Requirements
- R1: While reset is applied and through the first frame after release, the lane runs at default settings with an all-zero word, whatever the inputs are. Default settings are double rate, phase code 1, offset binary, least significant bit first, no pattern. In that frame `ser_o` stays 0 for all 20 ticks.
- R2: With default coding and order, bit slot i of a frame (ticks 2i and 2i+1) carries bit i of the captured sample, for i = 0..9.
- R3: With `twos_i`=1, the serialized word is the captured sample with only bit 9 inverted.
- R4: With `msb_first_i`=1, bit slot i carries word bit 9-i.
- R5: In double-rate mode a frame lasts 20 ticks and holds 10 bit slots. `fclk_o` is 1 for ticks 0..9 and 0 for ticks 10..19. `fclk_o` rises only on tick 0.
- R6: In double-rate mode, `bclk_o` at tick t is 1 exactly when ((t mod 4) - phase_i) mod 4 is 0 or 1. Phase codes 0..3 step the clock by a quarter period. Code 1 places one bit-clock edge in the centre of every bit.
- R7: In single-rate mode a frame lasts 24 ticks. The 10 data bits fill slots 0..9, slots 10 and 11 are driven 0, and `fclk_o` is 1 for ticks 0..11.
- R8: In single-rate mode, `bclk_o` ignores the phase code. With `sdr_fall_i`=0 it is 0 on the first tick of each slot and 1 on the second, which puts a rising edge mid-bit. With `sdr_fall_i`=1 it is the reverse.
- R9: With `pat_alt_i`=1, data slot i carries i mod 2, starting with 0. The padding slots of single-rate mode stay 0.
- R10: With `pat_sync_i`=1, data slots 0..4 carry 1 and slots 5..9 carry 0.
- R11: With both pattern enables set, the alternating pattern of R9 is sent.
- R12: The sample and all controls are captured only on the last tick of a frame. A change made during a frame changes neither that frame's data, nor its clocks, nor its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-bit tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | SAMPLE_W | Conversion result, captured at frame boundary |
| twos_i | input | 1 | 1 = two's complement output code |
| msb_first_i | input | 1 | 1 = most significant bit first |
| sdr_i | input | 1 | 1 = single-rate framing |
| sdr_fall_i | input | 1 | Single-rate: 1 = falling edge mid-bit |
| phase_i | input | 2 | Double-rate bit-clock phase code |
| pat_alt_i | input | 1 | Alternating test pattern enable |
| pat_sync_i | input | 1 | Half-ones/half-zeros test pattern enable |
| ser_o | output | 1 | Serial data |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame marker, high in first half of frame |

## Verification
The hardest case to reach is a control change that lands in the middle of a frame, above all one that also changes the frame length between double and single rate. The change must leave the current frame untouched, and the new setting must take effect only at the next boundary. The bench drives a new configuration a few ticks into a checked frame, in both directions between the two rates. It checks every tick of that frame against the old setting and every tick of the next frame against the new one. The sweep before this sends all 1024 sample values across the eight combinations of coding, order and rate.

// File: rtl/serfmt_pkg.sv
package serfmt_pkg;

   // Half-bit ticks per serial bit slot; the bit-clock phase steps rely on 2.
   localparam int unsigned TICKS_PER_SLOT = 2;

   typedef struct packed {
      logic       pat_alt;
      logic       pat_sync;
      logic       twos;
      logic       msb_first;
      logic       sdr;
      logic       sdr_fall;
      logic [1:0] phase;
   } serfmt_cfg_t;

   localparam serfmt_cfg_t CFG_RESET = '{
      pat_alt:   1'b0,
      pat_sync:  1'b0,
      twos:      1'b0,
      msb_first: 1'b0,
      sdr:       1'b0,
      sdr_fall:  1'b0,
      phase:     2'd1
   };

endpackage

// File: rtl/serfmt_frame_ctr.sv
module serfmt_frame_ctr #(
   parameter int unsigned DDR_TICKS = 20,
   parameter int unsigned SDR_TICKS = 24,
   parameter int unsigned CNT_W     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sdr_mode,
   output logic [CNT_W-1:0] tick_o,
   output logic             wrap_o
);

   localparam logic [CNT_W-1:0] DDR_LAST = CNT_W'(DDR_TICKS - 1);
   localparam logic [CNT_W-1:0] SDR_LAST = CNT_W'(SDR_TICKS - 1);

   logic [CNT_W-1:0] tick_q;
   logic [CNT_W-1:0] last_tick;

   assign last_tick = sdr_mode ? SDR_LAST : DDR_LAST;
   assign wrap_o    = (tick_q == last_tick);
   assign tick_o    = tick_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_q <= '0;
      end else if (wrap_o) begin
         tick_q <= '0;
      end else begin
         tick_q <= tick_q + 1'b1;
      end
   end

endmodule

// File: rtl/serfmt_bit_sel.sv
module serfmt_bit_sel
   import serfmt_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 10,
   parameter int unsigned SLOT_W   = 4
) (
   input  serfmt_cfg_t         cfg,
   input  logic [SAMPLE_W-1:0] word,
   input  logic [SLOT_W-1:0]   slot,
   output logic                bit_o
);

   localparam logic [SAMPLE_W-1:0] SIGN_FLIP  = {1'b1, {(SAMPLE_W-1){1'b0}}};
   localparam logic [SLOT_W-1:0]   DATA_SLOTS = SLOT_W'(SAMPLE_W);
   localparam logic [SLOT_W-1:0]   SYNC_ONES  = SLOT_W'(SAMPLE_W / 2);

   logic [SAMPLE_W-1:0] coded;
   logic [SAMPLE_W-1:0] reversed;
   logic [SAMPLE_W-1:0] ordered;
   logic                data_bit;
   logic                in_data;

   // Offset binary to two's complement: flip the top bit only.
   assign coded = cfg.twos ? (word ^ SIGN_FLIP) : word;

   for (genvar k = 0; k < SAMPLE_W; k++) begin : g_rev
      assign reversed[k] = coded[SAMPLE_W-1-k];
   end

   assign ordered = cfg.msb_first ? reversed : coded;

   always_comb begin
      data_bit = 1'b0;
      for (int k = 0; k < SAMPLE_W; k++) begin
         if (slot == SLOT_W'(k)) begin
            data_bit = ordered[k];
         end
      end
   end

   assign in_data = (slot < DATA_SLOTS);

   // Padding slots are low; deskew outranks sync, sync outranks data.
   always_comb begin
      if (!in_data) begin
         bit_o = 1'b0;
      end else if (cfg.pat_alt) begin
         bit_o = slot[0];
      end else if (cfg.pat_sync) begin
         bit_o = (slot < SYNC_ONES);
      end else begin
         bit_o = data_bit;
      end
   end

endmodule

// File: rtl/serfmt_clk_gen.sv
module serfmt_clk_gen
   import serfmt_pkg::*;
#(
   parameter int unsigned DDR_TICKS = 20,
   parameter int unsigned SDR_TICKS = 24,
   parameter int unsigned CNT_W     = 5
) (
   input  serfmt_cfg_t      cfg,
   input  logic [CNT_W-1:0] tick,
   output logic             bclk_o,
   output logic             fclk_o
);

   localparam logic [CNT_W-1:0] DDR_HALF = CNT_W'(DDR_TICKS / 2);
   localparam logic [CNT_W-1:0] SDR_HALF = CNT_W'(SDR_TICKS / 2);

   logic [1:0] quad;

   // Frame marker: high through the first half of the frame.
   assign fclk_o = (tick < (cfg.sdr ? SDR_HALF : DDR_HALF));

   // Double rate: four-tick bit clock, delayed by phase quarter periods.
   assign quad = tick[1:0] - cfg.phase;

   // Single rate: one bit-clock period per slot, edge chosen mid-bit.
   assign bclk_o = cfg.sdr ? (tick[0] ^ cfg.sdr_fall) : ~quad[1];

endmodule

// File: rtl/adc_lane_serializer.sv
module adc_lane_serializer
   import serfmt_pkg::*;
#(
   parameter int unsigned SAMPLE_W  = 10,
   parameter int unsigned SDR_SLOTS = 12,
   parameter bit          OUT_REG   = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] sample_i,
   input  logic                twos_i,
   input  logic                msb_first_i,
   input  logic                sdr_i,
   input  logic                sdr_fall_i,
   input  logic [1:0]          phase_i,
   input  logic                pat_alt_i,
   input  logic                pat_sync_i,
   output logic                ser_o,
   output logic                bclk_o,
   output logic                fclk_o
);

   localparam int unsigned DDR_TICKS = SAMPLE_W * TICKS_PER_SLOT;
   localparam int unsigned SDR_TICKS = SDR_SLOTS * TICKS_PER_SLOT;
   localparam int unsigned CNT_W     = $clog2(SDR_TICKS);
   localparam int unsigned SLOT_W    = CNT_W - 1;

   // Elaboration-time parameter checks.
   if (SAMPLE_W < 2 || (SAMPLE_W % 2) != 0) begin : g_bad_sample_w
      $error("SAMPLE_W must be even and at least 2");
   end
   if (SDR_SLOTS < SAMPLE_W || (SDR_SLOTS % 2) != 0) begin : g_bad_sdr_slots
      $error("SDR_SLOTS must be even and not below SAMPLE_W");
   end
   if (TICKS_PER_SLOT != 2) begin : g_bad_ticks
      $error("phase generation assumes two ticks per slot");
   end

   serfmt_cfg_t         cfg_in;
   serfmt_cfg_t         cfg_q;
   logic [SAMPLE_W-1:0] word_q;
   logic [CNT_W-1:0]    tick_w;
   logic                wrap_w;
   logic [SLOT_W-1:0]   slot_w;
   logic                ser_c;
   logic                bclk_c;
   logic                fclk_c;

   always_comb begin
      cfg_in           = CFG_RESET;
      cfg_in.pat_alt   = pat_alt_i;
      cfg_in.pat_sync  = pat_sync_i;
      cfg_in.twos      = twos_i;
      cfg_in.msb_first = msb_first_i;
      cfg_in.sdr       = sdr_i;
      cfg_in.sdr_fall  = sdr_fall_i;
      cfg_in.phase     = phase_i;
   end

   // Settings and sample change only at the frame boundary.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= CFG_RESET;
         word_q <= '0;
      end else if (wrap_w) begin
         cfg_q  <= cfg_in;
         word_q <= sample_i;
      end
   end

   serfmt_frame_ctr #(
      .DDR_TICKS (DDR_TICKS),
      .SDR_TICKS (SDR_TICKS),
      .CNT_W     (CNT_W)
   ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .sdr_mode (cfg_q.sdr),
      .tick_o   (tick_w),
      .wrap_o   (wrap_w)
   );

   assign slot_w = tick_w[CNT_W-1:1];

   serfmt_bit_sel #(
      .SAMPLE_W (SAMPLE_W),
      .SLOT_W   (SLOT_W)
   ) u_sel (
      .cfg   (cfg_q),
      .word  (word_q),
      .slot  (slot_w),
      .bit_o (ser_c)
   );

   serfmt_clk_gen #(
      .DDR_TICKS (DDR_TICKS),
      .SDR_TICKS (SDR_TICKS),
      .CNT_W     (CNT_W)
   ) u_clk (
      .cfg    (cfg_q),
      .tick   (tick_w),
      .bclk_o (bclk_c),
      .fclk_o (fclk_c)
   );

   if (OUT_REG) begin : g_oreg
      logic ser_q, bclk_q, fclk_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ser_q  <= 1'b0;
            bclk_q <= 1'b0;
            fclk_q <= 1'b0;
         end else begin
            ser_q  <= ser_c;
            bclk_q <= bclk_c;
            fclk_q <= fclk_c;
         end
      end
      assign ser_o  = ser_q;
      assign bclk_o = bclk_q;
      assign fclk_o = fclk_q;
   end else begin : g_comb
      assign ser_o  = ser_c;
      assign bclk_o = bclk_c;
      assign fclk_o = fclk_c;
   end

endmodule

// File: rtl/serfmt_chk.sv
module serfmt_chk
   import serfmt_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 10,
   parameter int unsigned CNT_W    = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] tick,
   input logic             wrap,
   input serfmt_cfg_t      cfg_q,
   input serfmt_cfg_t      cfg_in,
   input logic             ser_c,
   input logic             bclk_c,
   input logic             fclk_c
);

   localparam int unsigned        SLOT_W    = CNT_W - 1;
   localparam logic [SLOT_W-1:0]  W_SLOTS   = SLOT_W'(SAMPLE_W);
   localparam logic [SLOT_W-1:0]  HALF_W    = SLOT_W'(SAMPLE_W / 2);
   localparam logic [CNT_W-1:0]   TWO_TICKS = CNT_W'(2);

   logic [SLOT_W-1:0] slot;
   assign slot = tick[CNT_W-1:1];

   // R12: settings hold inside a frame
   a_r12_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(cfg_q));

   // R12: settings taken from the inputs at the boundary
   a_r12_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cfg_q == $past(cfg_in)));

   // R5: frame marker rises only at tick 0
   a_r5_fclk_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fclk_c) |-> (tick == '0));

   // R6: double-rate bit clock has a four-tick period
   a_r6_ddr_half_period: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_q.sdr && tick >= TWO_TICKS) |-> (bclk_c != $past(bclk_c, 2)));

   // R8: single-rate bit clock toggles every tick
   a_r8_sdr_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.sdr && tick != '0) |-> (bclk_c != $past(bclk_c)));

   // R7: padding slots low
   a_r7_pad_low: assert property (@(posedge clk) disable iff (!rst_n)
      (slot >= W_SLOTS) |-> !ser_c);

   // R9 / R11: alternating pattern wins whenever enabled
   a_r9_alt: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.pat_alt && slot < W_SLOTS) |-> (ser_c == slot[0]));

   // R10: sync pattern shape
   a_r10_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.pat_sync && !cfg_q.pat_alt && slot < W_SLOTS)
         |-> (ser_c == (slot < HALF_W)));

endmodule

bind adc_lane_serializer serfmt_chk #(
   .SAMPLE_W (SAMPLE_W),
   .CNT_W    (CNT_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick   (tick_w),
   .wrap   (wrap_w),
   .cfg_q  (cfg_q),
   .cfg_in (cfg_in),
   .ser_c  (ser_c),
   .bclk_c (bclk_c),
   .fclk_c (fclk_c)
);

// File: tb/adc_lane_serializer_bench.sv
`timescale 1ns/1ps
module adc_lane_serializer_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [9:0] sample;
   logic       twos, msb, sdr, fall, alt, sync;
   logic [1:0] phase;
   logic       ser, bclk, fclk;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // expected configuration of the frame under check
   logic [9:0] e_sample;
   logic       e_twos, e_msb, e_sdr, e_fall, e_alt, e_sync;
   logic [1:0] e_phase;

   // configuration driven mid-frame
   logic [9:0] n_sample;
   logic       n_twos, n_msb, n_sdr, n_fall, n_alt, n_sync;
   logic [1:0] n_phase;

   always #2.5 clk = ~clk;

   adc_lane_serializer u_adc_lane_serializer (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample_i    (sample),
      .twos_i      (twos),
      .msb_first_i (msb),
      .sdr_i       (sdr),
      .sdr_fall_i  (fall),
      .phase_i     (phase),
      .pat_alt_i   (alt),
      .pat_sync_i  (sync),
      .ser_o       (ser),
      .bclk_o      (bclk),
      .fclk_o      (fclk)
   );

   task automatic drive(input logic [9:0] s, input logic tw, input logic ms,
                        input logic sd, input logic fa, input logic [1:0] ph,
                        input logic al, input logic sy);
      sample = s; twos = tw; msb = ms; sdr = sd; fall = fa;
      phase = ph; alt = al; sync = sy;
   endtask

   task automatic expect_cfg(input logic [9:0] s, input logic tw, input logic ms,
                             input logic sd, input logic fa, input logic [1:0] ph,
                             input logic al, input logic sy);
      e_sample = s; e_twos = tw; e_msb = ms; e_sdr = sd; e_fall = fa;
      e_phase = ph; e_alt = al; e_sync = sy;
   endtask

   function automatic logic exp_ser(input int t);
      int slot;
      int idx;
      logic [9:0] w;
      slot = t / 2;
      if (slot >= 10) return 1'b0;
      if (e_alt) return (slot % 2) == 1;
      if (e_sync) return slot < 5;
      w = e_sample ^ (e_twos ? 10'h200 : 10'h000);
      idx = e_msb ? 9 - slot : slot;
      return w[idx];
   endfunction

   function automatic logic exp_bclk(input int t);
      int x;
      if (e_sdr) return e_fall ? ((t % 2) == 0) : ((t % 2) == 1);
      x = ((t % 4) - int'(e_phase) + 4) % 4;
      return x < 2;
   endfunction

   function automatic logic exp_fclk(input int t);
      return t < (e_sdr ? 12 : 10);
   endfunction

   task automatic wait_start();
      logic prev;
      prev = fclk;
      @(negedge clk);
      while (!(fclk && !prev)) begin
         prev = fclk;
         @(negedge clk);
      end
   endtask

   task automatic check_frame(input string req, input int mid_at);
      int n;
      n = e_sdr ? 24 : 20;
      for (int t = 0; t < n; t++) begin
         if (t > 0) @(negedge clk);
         if (t == mid_at)
            drive(n_sample, n_twos, n_msb, n_sdr, n_fall, n_phase, n_alt, n_sync);
         n_tests++;
         if ({ser, bclk, fclk} !== {exp_ser(t), exp_bclk(t), exp_fclk(t)}) begin
            n_fail++;
            $display("FAIL %s tick %0d: ser/bclk/fclk actual %b%b%b expected %b%b%b",
                     req, t, ser, bclk, fclk, exp_ser(t), exp_bclk(t), exp_fclk(t));
         end
      end
   endtask

   task automatic run(input logic [9:0] s, input logic tw, input logic ms,
                      input logic sd, input logic fa, input logic [1:0] ph,
                      input logic al, input logic sy, input string req);
      drive(s, tw, ms, sd, fa, ph, al, sy);
      expect_cfg(s, tw, ms, sd, fa, ph, al, sy);
      wait_start();
      check_frame(req, -1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      string req;
      rst_n = 1'b0;
      // R1: non-default inputs during reset must not reach the first frame
      drive(10'h3FF, 1'b1, 1'b1, 1'b1, 1'b1, 2'd3, 1'b0, 1'b1);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #0.1;
      expect_cfg(10'h000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0);
      check_frame("R1", -1);

      // R2 R3 R4 R5 R7: all 1024 samples over coding/order/rate combinations
      for (int c = 0; c < 8; c++) begin
         for (int k = 0; k < 128; k++) begin
            logic tw, ms, sd;
            tw = (c % 2) == 1;
            ms = ((c / 2) % 2) == 1;
            sd = ((c / 4) % 2) == 1;
            if (sd) req = "R7";
            else if (tw) req = "R3";
            else if (ms) req = "R4";
            else req = "R2/R5";
            run(10'(k * 8 + c), tw, ms, sd, 1'b0, 2'd1, 1'b0, 1'b0, req);
         end
      end

      // R6: all four double-rate phase codes
      for (int p = 0; p < 4; p++)
         run(10'h2C6, 1'b0, 1'b0, 1'b0, 1'b0, 2'(p), 1'b0, 1'b0, "R6");

      // R8: single-rate edge placement, phase code ignored
      run(10'h1E7, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, "R8");
      run(10'h1E7, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, "R8");

      // R9 / R10 / R11: test patterns in both rates
      run(10'h3FF, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, "R9");
      run(10'h3FF, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, "R9");
      run(10'h000, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, "R10");
      run(10'h155, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, "R10");
      run(10'h2AA, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, "R11");
      run(10'h0F0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 1'b1, 1'b1, "R11");

      // R12: double-rate frame, change to single rate at tick 3
      drive(10'h0F3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0);
      expect_cfg(10'h0F3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0);
      wait_start();
      n_sample = 10'h30C; n_twos = 1'b1; n_msb = 1'b1; n_sdr = 1'b1;
      n_fall = 1'b1; n_phase = 2'd0; n_alt = 1'b0; n_sync = 1'b0;
      check_frame("R12", 3);
      expect_cfg(10'h30C, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0);
      wait_start();
      // R12: single-rate frame, change back to double rate at tick 7
      n_sample = 10'h2B1; n_twos = 1'b0; n_msb = 1'b0; n_sdr = 1'b0;
      n_fall = 1'b0; n_phase = 2'd2; n_alt = 1'b0; n_sync = 1'b1;
      check_frame("R12", 7);
      expect_cfg(10'h2B1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1);
      wait_start();
      check_frame("R12", -1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule